// File: doc/BRIEF.md
# Banked Register-File Addressing Unit

This unit is the data-memory access path of a small 8-bit controller. An instruction supplies a 7-bit file address together with read and write strobes. The unit turns that address into a location in a banked data memory and returns the read data. It also holds the two pieces of addressing state, the pointer register and the bank-select bits, and exposes both as outputs.

Every file address except one is a direct access. The unit places the current bank bits above the 7-bit field to pick one of the banks of 128 locations. The remaining address, location 00h, has no storage. An access there is steered to the location named by the 8-bit pointer. Pointer bit 7 picks the low or high bank, and pointer bits 6:0 pick the location. When the pointer names location 00h itself, in either bank, a read returns zero and a write changes nothing. The upper bank bit and the indirect-half bit are reserved and always read as zero, so only banks 0 and 1 can be reached.

Reads are combinational from the current address, pointer and bank bits. Writes commit on the rising clock edge. This lets software clear a block of memory at full rate by alternating a zero write through location 00h with an increment of the pointer.

Top module: `bank_file_access`

## Requirements
- R1: While reset is held, and until the first write after it, ptr_out reads 00h and bank_out reads 2'b00. With rd_en low, rd_data reads 00h.
- R2: A direct access to file address A (any A other than 00h, 03h or 04h) reaches memory location {bank_out[0], A[6:0]}. The same A in bank 0 and in bank 1 holds independent values.
- R3: File address 04h is the pointer register in both banks. A write there loads ptr_out with wr_data on the next clock edge, and a read returns ptr_out.
- R4: File address 03h is the bank-select register in both banks. Bit 0 is the low bank select and can be written. Bit 1 is the reserved upper bank select and bit 2 the reserved indirect-half select. Both read 0, and writes to them are ignored. Bits 7:3 read 0. bank_out shows {bit 1, bit 0}.
- R5: An access to file address 00h goes to the location named by ptr_out: pointer bit 7 selects the bank and bits 6:0 the location, whatever bank_out holds. This includes locations 03h and 04h.
- R6: When ptr_out[6:0] is 00h (pointer 00h or 80h), a read of file address 00h returns 00h.
- R7: When ptr_out[6:0] is 00h, a write to file address 00h leaves memory, ptr_out and bank_out unchanged.
- R8: A write commits on the rising clock edge. A read in the following cycle returns the new value. A zero write through file address 00h and a pointer increment can alternate on every cycle.
- R9: While rd_en is low, rd_data is 00h whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| file_addr | input | 7 | File address field of the instruction |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| ptr_out | output | 8 | Current pointer register value |
| bank_out | output | 2 | Current bank-select bits {upper, lower} |

## Verification
Read data is due in the same cycle as the address and strobe, because no register lies on the read path. The bench drives each operation just after a falling edge and samples rd_data one nanosecond later, well before the next rising edge. A write shows up on ptr_out, bank_out or in memory only after that rising edge. The bench therefore checks register outputs, and reads back memory, one cycle after the write, never in the write cycle. Reset release passes through a two-stage synchronizer, so the bench allows three rising edges after deasserting rst_n before it issues any operation.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

  // Which storage element an access resolves to
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_BSEL = 2'd3
  } tgt_e;

endpackage

// File: rtl/bfa_rst_sync.sv
module bfa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bfa_addr_gen.sv
module bfa_addr_gen
  import bfa_pkg::*;
#(
  parameter int          LOC_W     = 7,
  parameter int          PTR_W     = 8,
  parameter int          NUM_BANKS = 2,
  parameter logic [6:0]  IND_LOC   = 7'h00,
  parameter logic [6:0]  BSEL_LOC  = 7'h03,
  parameter logic [6:0]  PTR_LOC   = 7'h04,
  localparam int         EA_W      = LOC_W + 2,
  localparam int         RB_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int         RAM_AW    = RB_W + LOC_W
) (
  input  logic [LOC_W-1:0]  file_addr,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [1:0]        rp_q,
  input  logic              irp_q,
  output tgt_e              tgt,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              self_ref
);

  logic             is_ind;
  logic [EA_W-1:0]  ea;
  logic [LOC_W-1:0] loc;
  logic [1:0]       bank;

  always_comb begin
    is_ind = (file_addr == IND_LOC[LOC_W-1:0]);
    // Indirect: half bit above the full pointer; direct: bank bits above the field
    if (is_ind) ea = {irp_q, ptr_q};
    else        ea = {rp_q, file_addr};
    loc  = ea[LOC_W-1:0];
    bank = ea[EA_W-1:LOC_W];

    self_ref = is_ind && (loc == IND_LOC[LOC_W-1:0]);

    if (self_ref)                              tgt = TGT_NONE;
    else if (loc == PTR_LOC[LOC_W-1:0])        tgt = TGT_PTR;
    else if (loc == BSEL_LOC[LOC_W-1:0])       tgt = TGT_BSEL;
    else if (int'(bank) < NUM_BANKS)           tgt = TGT_RAM;
    else                                       tgt = TGT_NONE;

    ram_addr = {bank[RB_W-1:0], loc};
  end

endmodule

// File: rtl/bfa_ctrl_regs.sv
module bfa_ctrl_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic              bsel_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q,
  output logic [1:0]        rp_q,
  output logic              irp_q,
  output logic [DATA_W-1:0] bsel_rd
);

  logic [DATA_W-1:0] ptr_d;
  logic              rp0_q;
  logic              rp0_d;

  // Next-state with written-out enables
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we) ptr_d = wdata;
    rp0_d = rp0_q;
    if (bsel_we) rp0_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rp0_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      rp0_q <= rp0_d;
    end
  end

  // Reserved selects are tied low
  assign rp_q    = {1'b0, rp0_q};
  assign irp_q   = 1'b0;
  assign bsel_rd = {{(DATA_W-3){1'b0}}, irp_q, rp_q};

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_q == $past(wdata)));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> $stable(ptr_q));

  assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bsel_we |=> (rp_q == {1'b0, $past(wdata[0])}));

  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bsel_we |=> $stable(rp_q));

endmodule

// File: rtl/bfa_data_ram.sv
module bfa_data_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/bank_file_access.sv
module bank_file_access
  import bfa_pkg::*;
#(
  parameter int LOC_W     = 7,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int RB_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RAM_AW   = RB_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  file_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ptr_out,
  output logic [1:0]        bank_out
);

  logic              rst_n_i;
  tgt_e              tgt;
  logic [RAM_AW-1:0] ram_addr;
  logic              self_ref;
  logic [DATA_W-1:0] ptr_q;
  logic [1:0]        rp_q;
  logic              irp_q;
  logic [DATA_W-1:0] bsel_rd;
  logic [DATA_W-1:0] ram_rd;
  logic              ram_we;
  logic              ptr_we;
  logic              bsel_we;

  bfa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bfa_addr_gen #(
    .LOC_W     (LOC_W),
    .PTR_W     (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_agen (
    .file_addr (file_addr),
    .ptr_q     (ptr_q),
    .rp_q      (rp_q),
    .irp_q     (irp_q),
    .tgt       (tgt),
    .ram_addr  (ram_addr),
    .self_ref  (self_ref)
  );

  always_comb begin
    ram_we  = wr_en && (tgt == TGT_RAM);
    ptr_we  = wr_en && (tgt == TGT_PTR);
    bsel_we = wr_en && (tgt == TGT_BSEL);
  end

  bfa_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ptr_we  (ptr_we),
    .bsel_we (bsel_we),
    .wdata   (wr_data),
    .ptr_q   (ptr_q),
    .rp_q    (rp_q),
    .irp_q   (irp_q),
    .bsel_rd (bsel_rd)
  );

  bfa_data_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (wr_data),
    .rdata (ram_rd)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (tgt)
        TGT_RAM:  rd_data = ram_rd;
        TGT_PTR:  rd_data = ptr_q;
        TGT_BSEL: rd_data = bsel_rd;
        default:  rd_data = '0;
      endcase
    end
  end

  assign ptr_out  = ptr_q;
  assign bank_out = rp_q;

  assert_selfref_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && self_ref) |-> (!ram_we && !ptr_we && !bsel_we));

  assert_selfref_zero_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_en && self_ref) |-> (rd_data == '0));

  assert_reserved_bank_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bank_out[1] == 1'b0) && (irp_q == 1'b0));

  assert_direct_bank_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ram_we && (file_addr != '0)) |-> (ram_addr[LOC_W] == bank_out[0]));

endmodule

// File: tb/bank_file_access_test.sv
module bank_file_access_test;

  logic       clk;
  logic       rst_n;
  logic [6:0] file_addr;
  logic       rd_en;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] ptr_out;
  logic [1:0] bank_out;

  int checks;
  int errors;
  logic [7:0] ref_mem [256];
  logic [7:0] exp_ptr;
  logic       exp_rp0;

  bank_file_access uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .file_addr (file_addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ptr_out   (ptr_out),
    .bank_out  (bank_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One operation per cycle: drive after falling edge, sample read 1 ns later,
  // commit at the rising edge, release strobes 1 ns after it.
  task automatic op(input logic [6:0] a, input logic we, input logic re,
                    input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    file_addr = a; wr_en = we; rd_en = re; wr_data = wd;
    #1 rd = rd_data;
    @(posedge clk);
    #1 wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] wd);
    logic [7:0] dummy;
    op(a, 1'b1, 1'b0, wd, dummy);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    op(a, 1'b0, 1'b1, 8'h00, v);
  endtask

  task automatic set_bank(input logic b);
    wr(7'h03, {7'h00, b});
    exp_rp0 = b;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    wr(7'h04, p);
    exp_ptr = p;
  endtask

  task automatic test_reset;
    rst_n = 1'b0; file_addr = 7'h20; rd_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ptr in reset", ptr_out, 8'h00);
    chk("R1 bank in reset", {6'h0, bank_out}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ptr after reset", ptr_out, 8'h00);
    chk("R1 bank after reset", {6'h0, bank_out}, 8'h00);
    chk("R1 idle rd_data", rd_data, 8'h00);
    exp_ptr = 8'h00; exp_rp0 = 1'b0;
  endtask

  task automatic test_direct_banks;
    logic [7:0] v;
    for (int b = 0; b < 2; b++) begin
      set_bank(b[0]);
      for (int i = 0; i < 6; i++) begin
        logic [6:0] a = 7'h20 + 7'(i * 9);
        logic [7:0] d = 8'(8'h11 * (i + 1)) ^ (b[0] ? 8'hC3 : 8'h00);
        wr(a, d);
        ref_mem[{b[0], a}] = d;
      end
    end
    for (int b = 0; b < 2; b++) begin
      set_bank(b[0]);
      chk("R4 bank_out", {6'h0, bank_out}, {7'h0, b[0]});
      for (int i = 0; i < 6; i++) begin
        logic [6:0] a = 7'h20 + 7'(i * 9);
        rd(a, v);
        chk("R2 direct bank read", v, ref_mem[{b[0], a}]);
      end
    end
    // Top and bottom of the general region in bank 1
    set_bank(1'b1);
    wr(7'h7F, 8'h9E); ref_mem[8'hFF] = 8'h9E;
    wr(7'h05, 8'h3B); ref_mem[8'h85] = 8'h3B;
    rd(7'h7F, v); chk("R2 bank1 7Fh", v, 8'h9E);
    rd(7'h05, v); chk("R2 bank1 05h", v, 8'h3B);
  endtask

  task automatic test_special_regs;
    logic [7:0] v;
    set_bank(1'b1);
    set_ptr(8'h5C);
    chk("R3 ptr_out after write", ptr_out, 8'h5C);
    set_bank(1'b0);
    rd(7'h04, v); chk("R3 ptr mirrored in bank0", v, 8'h5C);
    wr(7'h03, 8'hFF); exp_rp0 = 1'b1;
    chk("R4 reserved bits ignored", {6'h0, bank_out}, 8'h01);
    rd(7'h03, v); chk("R4 bank reg readback", v, 8'h01);
    wr(7'h03, 8'hFE); exp_rp0 = 1'b0;
    rd(7'h03, v); chk("R4 bank reg cleared", v, 8'h00);
  endtask

  task automatic test_indirect;
    logic [7:0] v;
    set_bank(1'b0);
    set_ptr(8'hA5);
    wr(7'h00, 8'h5A); ref_mem[8'hA5] = 8'h5A;
    set_bank(1'b1);
    rd(7'h25, v); chk("R5 indirect write to bank1", v, 8'h5A);
    set_ptr(8'h29);
    rd(7'h00, v); chk("R5 indirect read bank0 while bank1 set", v, ref_mem[8'h29]);
    set_bank(1'b0);
    set_ptr(8'h83);
    rd(7'h00, v); chk("R5 indirect reaches bank reg", v, 8'h00);
    set_ptr(8'h04);
    wr(7'h00, 8'h31); exp_ptr = 8'h31;
    chk("R5 indirect write to pointer", ptr_out, 8'h31);
  endtask

  task automatic test_clear_loop;
    logic [7:0] v;
    logic [7:0] dummy;
    set_bank(1'b0);
    for (int i = 0; i < 17; i++) begin
      wr(7'(8'h20 + i), 8'(8'hE0 + i));
      ref_mem[8'h20 + i] = 8'(8'hE0 + i);
    end
    set_ptr(8'h20);
    while (!exp_ptr[4]) begin
      wr(7'h00, 8'h00); ref_mem[exp_ptr] = 8'h00;
      op(7'h04, 1'b1, 1'b1, exp_ptr + 8'h01, dummy);
      exp_ptr = exp_ptr + 8'h01;
    end
    chk("R8 pointer at end of clear", ptr_out, 8'h30);
    for (int i = 0; i < 16; i++) begin
      rd(7'(8'h20 + i), v);
      chk("R8 cleared location", v, 8'h00);
    end
    rd(7'h30, v); chk("R8 location past block kept", v, 8'hF0);
    wr(7'h41, 8'h6D);
    rd(7'h41, v); chk("R8 read next cycle after write", v, 8'h6D);
    ref_mem[8'h41] = 8'h6D;
  endtask

  task automatic test_self_ref;
    logic [7:0] v;
    set_bank(1'b1);
    set_ptr(8'h00);
    rd(7'h00, v); chk("R6 self read ptr 00h", v, 8'h00);
    wr(7'h00, 8'h77);
    chk("R7 ptr unchanged", ptr_out, 8'h00);
    chk("R7 bank unchanged", {6'h0, bank_out}, 8'h01);
    set_ptr(8'h80);
    rd(7'h00, v); chk("R6 self read ptr 80h", v, 8'h00);
    wr(7'h00, 8'h66);
    chk("R7 ptr unchanged 80h", ptr_out, 8'h80);
    rd(7'h25, v); chk("R7 bank1 memory kept", v, ref_mem[8'hA5]);
    set_bank(1'b0);
    rd(7'h41, v); chk("R7 bank0 memory kept", v, ref_mem[8'h41]);
  endtask

  task automatic test_idle;
    logic [7:0] v;
    set_bank(1'b0);
    op(7'h41, 1'b0, 1'b0, 8'h00, v); chk("R9 rd_en low on RAM", v, 8'h00);
    op(7'h04, 1'b0, 1'b0, 8'h00, v); chk("R9 rd_en low on pointer", v, 8'h00);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    test_reset;
    test_direct_banks;
    test_special_regs;
    test_indirect;
    test_clear_loop;
    test_self_ref;
    test_idle;
    summary;
  end

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

endmodule